// File: doc/BRIEF.md
# Instruction Line Fetch Requester

This block sits between a multithreaded fetch stage and the instruction memory. For each thread it keeps one buffered cache line, a tag naming the line's aligned address, a valid bit, and a one-bit request epoch. A fetch names a thread and a byte address. The block clears the address's low offset bits to get the line address. If that thread's buffer already holds the line, the block signals a hit. Otherwise it sends a whole-line read over a valid/ready request port. Each request carries a tag made of the thread index and the thread's new epoch, so the response returns to the right thread and responses from abandoned requests can be recognised.

A request that memory refuses is saved in one retry slot shared by all threads. While the slot holds it, the port counts as blocked and no thread may start a new request. A retry pulse from memory resends the saved request. A response is accepted only when it matches the outstanding request of a thread that is waiting for it. Any other response is dropped and counted. A squash returns a thread to its ready state, abandons its outstanding miss, and frees the retry slot if the thread owns it.

Each thread runs its own state machine. READY (0) accepts fetches. WAIT_RETRY (1) holds a refused request. WAIT_RSP (2) waits for line data. DONE (3) marks a line that has just been filled. BLOCKED (4) is held while a downstream stall is active. The transitions are as follows. READY or DONE goes to WAIT_RSP on an accepted issue, to WAIT_RETRY on a refused issue, and to BLOCKED on a stall. DONE goes to READY after one idle cycle. WAIT_RETRY goes to WAIT_RSP when the resend is accepted. WAIT_RSP goes to DONE on a fill, or to BLOCKED on a fill during a stall. BLOCKED goes to READY when the stall drops. A squash takes any state to READY.

Top module: `line_fetch_req`

## Requirements
- R1: A request's address is the fetch address with its low log2(LINE_BYTES) bits cleared (6 bits for 64-byte lines). Its tag holds the thread index in bits [TID_W-1:0] and the epoch in bit TID_W. A thread's epoch is 0 after reset and flips on every request that thread issues.
- R2: A fetch by a READY or DONE thread whose buffer is valid and whose tag equals the aligned address raises fetch_hit in the same cycle and sends no request.
- R3: No fetch produces a request or a hit in any of these cases: port_blocked is 1; switched_out is 1; intr_pending is 1 while fetch_priv is 0. When intr_pending is 1 and fetch_priv is 1, the fetch proceeds normally.
- R4: When a request is issued, the thread's buffer tag (seen on rd_tag) becomes the aligned address and line_valid for that thread drops to 0 on the next cycle.
- R5: A request that is refused (mem_req_valid with mem_req_ready low) is saved. port_blocked becomes 1 and the thread enters WAIT_RETRY (1).
- R6: On mem_retry with a saved request, the same address and tag are presented again. If accepted, the thread enters WAIT_RSP (2) and port_blocked clears. If refused, nothing changes.
- R7: mem_retry with no saved request sends no request and leaves port_blocked at 0.
- R8: A response is accepted only when all of these hold: its thread is in WAIT_RSP; its epoch bit and address both match that thread's outstanding request; the thread is not being squashed; switched_out is 0. Every other response adds one to drop_count.
- R9: An accepted response stores the line data and sets line_valid. The thread enters BLOCKED (4) if its stall input is high, otherwise DONE (3). DONE returns to READY on the next cycle.
- R10: Squashing a thread returns it to READY. If it owns the saved request, the request is discarded and port_blocked clears. A later response to its abandoned miss is dropped.
- R11: A READY thread with its stall input high enters BLOCKED and accepts no fetch. It returns to READY the cycle after the stall drops.
- R12: After reset every thread is READY with line_valid 0, port_blocked is 0, and drop_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch attempt this cycle |
| fetch_tid | input | TID_W | Thread of the fetch |
| fetch_addr | input | ADDR_W | Byte address to fetch |
| fetch_priv | input | 1 | Fetch runs in privileged (physical) mode |
| intr_pending | input | 1 | Interrupt pending; holds unprivileged fetches |
| switched_out | input | 1 | Block is switched out; no requests or fills |
| squash | input | NUM_THR | Per-thread squash |
| stall | input | NUM_THR | Per-thread downstream stall |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_addr | output | ADDR_W | Aligned line address |
| mem_req_tag | output | TID_W+1 | {epoch, thread} |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_retry | input | 1 | Memory can now take the refused request |
| mem_rsp_valid | input | 1 | Line response valid |
| mem_rsp_addr | input | ADDR_W | Address of the returned line |
| mem_rsp_tag | input | TID_W+1 | Tag of the returned line |
| mem_rsp_data | input | LINE_BYTES*8 | Returned line data |
| fetch_hit | output | 1 | Fetch satisfied from the buffered line |
| port_blocked | output | 1 | A refused request awaits retry |
| thr_state | output | NUM_THR*3 | Per-thread state codes, thread i at [3i+2:3i] |
| line_valid | output | NUM_THR | Per-thread buffer valid |
| rd_tid | input | TID_W | Thread selected for buffer readout |
| rd_data | output | LINE_BYTES*8 | Selected thread's line data |
| rd_tag | output | ADDR_W | Selected thread's line tag |
| drop_count | output | CNT_W | Count of discarded responses (saturating) |

## Verification
The bench walks both threads through addresses at many in-line offsets, then sweeps all eight combinations of switched-out, interrupt and privilege. A design that aligned the address wrongly, or ignored the privilege exemption, would issue the wrong address or block a fetch it should not. Refusal is tested with a retry that is itself refused, a retry that is accepted, and a retry with an empty slot. A design that lost the saved tag, or stayed blocked after the slot emptied, would stall every thread. Squash tests cover both a squash of the slot owner and a squash of an outstanding miss. Responses with a stale epoch, a wrong address, an idle thread or switched-out set must each raise drop_count without filling the buffer. A design that matched on thread alone would take stale data as a fill.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        TS_READY      = 3'd0,
        TS_WAIT_RETRY = 3'd1,
        TS_WAIT_RSP   = 3'd2,
        TS_DONE       = 3'd3,
        TS_BLOCKED    = 3'd4
    } thr_state_e;

endpackage

// File: rtl/lfr_thread_fsm.sv
module lfr_thread_fsm
    import lfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       squash_i,
    input  logic       stall_i,
    input  logic       issue_i,
    input  logic       issue_acc_i,
    input  logic       resend_acc_i,
    input  logic       fill_i,
    output thr_state_e state_o,
    output logic       ready_o
);

    thr_state_e state_q;
    thr_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TS_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (squash_i) begin
            state_d = TS_READY;
        end else begin
            unique case (state_q)
                TS_READY, TS_DONE: begin
                    if (stall_i)              state_d = TS_BLOCKED;
                    else if (issue_i)         state_d = issue_acc_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
                    else                      state_d = TS_READY;
                end
                TS_WAIT_RETRY: if (resend_acc_i) state_d = TS_WAIT_RSP;
                TS_WAIT_RSP:   if (fill_i)       state_d = stall_i ? TS_BLOCKED : TS_DONE;
                TS_BLOCKED:    if (!stall_i)     state_d = TS_READY;
                default:                         state_d = TS_READY;
            endcase
        end
    end

    always_comb begin
        state_o = state_q;
        ready_o = (state_q == TS_READY || state_q == TS_DONE) && !stall_i && !squash_i;
    end

    // R6
    wait_retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_WAIT_RETRY && !squash_i && !resend_acc_i) |=> state_q == TS_WAIT_RETRY);

    // R9
    fill_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |-> state_q == TS_WAIT_RSP);

    // R10
    squash_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> state_q == TS_READY);

endmodule

// File: rtl/lfr_retry_slot.sv
module lfr_retry_slot #(
    parameter int NUM_THR = 2,
    parameter int ADDR_W  = 32,
    parameter int TID_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                save_i,
    input  logic [ADDR_W-1:0]   save_addr_i,
    input  logic [TID_W:0]      save_tag_i,
    input  logic                retry_i,
    input  logic                send_ready_i,
    input  logic [NUM_THR-1:0]  squash_i,
    output logic                resend_o,
    output logic                resend_acc_o,
    output logic [ADDR_W-1:0]   slot_addr_o,
    output logic [TID_W:0]      slot_tag_o,
    output logic                blocked_o
);

    logic              slot_v_q;
    logic              blocked_q;
    logic [ADDR_W-1:0] slot_addr_q;
    logic [TID_W:0]    slot_tag_q;
    logic              owner_sq;

    always_comb begin
        owner_sq = 1'b0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (squash_i[i] && slot_tag_q[TID_W-1:0] == TID_W'(i)) owner_sq = 1'b1;
        end
    end

    assign resend_o     = retry_i && slot_v_q && !owner_sq;
    assign resend_acc_o = resend_o && send_ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v_q    <= 1'b0;
            blocked_q   <= 1'b0;
            slot_addr_q <= '0;
            slot_tag_q  <= '0;
        end else if (slot_v_q && owner_sq) begin
            slot_v_q  <= 1'b0;
            blocked_q <= 1'b0;
        end else if (resend_acc_o) begin
            slot_v_q  <= 1'b0;
            blocked_q <= 1'b0;
        end else if (save_i) begin
            slot_v_q    <= 1'b1;
            blocked_q   <= 1'b1;
            slot_addr_q <= save_addr_i;
            slot_tag_q  <= save_tag_i;
        end else if (retry_i && !slot_v_q) begin
            blocked_q <= 1'b0;
        end
    end

    assign slot_addr_o = slot_addr_q;
    assign slot_tag_o  = slot_tag_q;
    assign blocked_o   = blocked_q;

    // R5
    save_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |-> !blocked_q);

    // R7
    empty_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_i && !slot_v_q && !save_i) |=> !blocked_q);

    // R10
    owner_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_v_q && owner_sq) |=> (!slot_v_q && !blocked_q));

endmodule

// File: rtl/lfr_line_buf.sv
module lfr_line_buf #(
    parameter int NUM_THR = 2,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 512,
    parameter int TID_W   = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_THR-1:0]                issue_i,
    input  logic [ADDR_W-1:0]                 issue_addr_i,
    input  logic [NUM_THR-1:0]                fill_i,
    input  logic [DATA_W-1:0]                 fill_data_i,
    input  logic [TID_W-1:0]                  rd_tid_i,
    output logic [NUM_THR-1:0][ADDR_W-1:0]    tag_o,
    output logic [NUM_THR-1:0]                valid_o,
    output logic [NUM_THR-1:0]                epoch_o,
    output logic [DATA_W-1:0]                 rd_data_o,
    output logic [ADDR_W-1:0]                 rd_tag_o
);

    logic [DATA_W-1:0] data_a [NUM_THR];

    for (genvar i = 0; i < NUM_THR; i++) begin : g_entry
        logic [ADDR_W-1:0] tag_r;
        logic              valid_r;
        logic              epoch_r;
        logic [DATA_W-1:0] data_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_r   <= '0;
                valid_r <= 1'b0;
                epoch_r <= 1'b0;
                data_r  <= '0;
            end else if (issue_i[i]) begin
                tag_r   <= issue_addr_i;
                valid_r <= 1'b0;
                epoch_r <= ~epoch_r;
            end else if (fill_i[i]) begin
                data_r  <= fill_data_i;
                valid_r <= 1'b1;
            end
        end

        assign tag_o[i]   = tag_r;
        assign valid_o[i] = valid_r;
        assign epoch_o[i] = epoch_r;
        assign data_a[i]  = data_r;

        // R4
        issue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            issue_i[i] |=> (!valid_r && tag_r == $past(issue_addr_i)));
    end

    always_comb begin
        rd_data_o = '0;
        rd_tag_o  = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (rd_tid_i == TID_W'(i)) begin
                rd_data_o = data_a[i];
                rd_tag_o  = tag_o[i];
            end
        end
    end

endmodule

// File: rtl/line_fetch_req.sv
module line_fetch_req
    import lfr_pkg::*;
#(
    parameter int NUM_THR    = 2,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int CNT_W      = 16,
    localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
    localparam int DATA_W    = LINE_BYTES * 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fetch_valid,
    input  logic [TID_W-1:0]            fetch_tid,
    input  logic [ADDR_W-1:0]           fetch_addr,
    input  logic                        fetch_priv,
    input  logic                        intr_pending,
    input  logic                        switched_out,
    input  logic [NUM_THR-1:0]          squash,
    input  logic [NUM_THR-1:0]          stall,
    output logic                        mem_req_valid,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [TID_W:0]              mem_req_tag,
    input  logic                        mem_req_ready,
    input  logic                        mem_retry,
    input  logic                        mem_rsp_valid,
    input  logic [ADDR_W-1:0]           mem_rsp_addr,
    input  logic [TID_W:0]              mem_rsp_tag,
    input  logic [DATA_W-1:0]           mem_rsp_data,
    output logic                        fetch_hit,
    output logic                        port_blocked,
    output logic [NUM_THR*STATE_W-1:0]  thr_state,
    output logic [NUM_THR-1:0]          line_valid,
    input  logic [TID_W-1:0]            rd_tid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [ADDR_W-1:0]           rd_tag,
    output logic [CNT_W-1:0]            drop_count
);

    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0]              aligned;
    logic                           gate_open;
    logic [NUM_THR-1:0][ADDR_W-1:0] buf_tag;
    logic [NUM_THR-1:0]             buf_valid;
    logic [NUM_THR-1:0]             buf_epoch;
    logic [NUM_THR-1:0]             thr_ready;
    logic [NUM_THR-1:0]             hit_vec;
    logic [NUM_THR-1:0]             issue_vec;
    logic [NUM_THR-1:0]             fill_vec;
    logic [NUM_THR-1:0]             resend_acc_vec;
    logic                           issue_any;
    logic                           issue_ep;
    logic                           save;
    logic                           resend;
    logic                           resend_acc;
    logic [ADDR_W-1:0]              slot_addr;
    logic [TID_W:0]                 slot_tag;
    logic                           blocked;
    logic [TID_W-1:0]               rsp_tid;
    logic                           rsp_ep;
    logic [CNT_W-1:0]               drop_q;

    assign aligned   = fetch_addr & ~OFF_MASK;
    assign gate_open = !blocked && !switched_out && !(intr_pending && !fetch_priv);
    assign rsp_tid   = mem_rsp_tag[TID_W-1:0];
    assign rsp_ep    = mem_rsp_tag[TID_W];

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        thr_state_e st;
        logic       want;
        logic       match;

        assign match = buf_valid[i] && (buf_tag[i] == aligned);
        assign want  = fetch_valid && (fetch_tid == TID_W'(i)) && thr_ready[i] && gate_open;
        assign hit_vec[i]   = want && match;
        assign issue_vec[i] = want && !match;
        assign fill_vec[i]  = mem_rsp_valid && (rsp_tid == TID_W'(i)) && (st == TS_WAIT_RSP)
                              && (rsp_ep == buf_epoch[i]) && (mem_rsp_addr == buf_tag[i])
                              && !squash[i] && !switched_out;
        assign resend_acc_vec[i] = resend_acc && (slot_tag[TID_W-1:0] == TID_W'(i));

        lfr_thread_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .squash_i     (squash[i]),
            .stall_i      (stall[i]),
            .issue_i      (issue_vec[i]),
            .issue_acc_i  (mem_req_ready),
            .resend_acc_i (resend_acc_vec[i]),
            .fill_i       (fill_vec[i]),
            .state_o      (st),
            .ready_o      (thr_ready[i])
        );

        assign thr_state[i*STATE_W +: STATE_W] = st;
    end

    assign issue_any = |issue_vec;
    assign issue_ep  = |(issue_vec & ~buf_epoch);
    assign save      = issue_any && !mem_req_ready;

    lfr_retry_slot #(
        .NUM_THR (NUM_THR),
        .ADDR_W  (ADDR_W),
        .TID_W   (TID_W)
    ) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .save_i       (save),
        .save_addr_i  (aligned),
        .save_tag_i   ({issue_ep, fetch_tid}),
        .retry_i      (mem_retry),
        .send_ready_i (mem_req_ready),
        .squash_i     (squash),
        .resend_o     (resend),
        .resend_acc_o (resend_acc),
        .slot_addr_o  (slot_addr),
        .slot_tag_o   (slot_tag),
        .blocked_o    (blocked)
    );

    lfr_line_buf #(
        .NUM_THR (NUM_THR),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TID_W   (TID_W)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_i      (issue_vec),
        .issue_addr_i (aligned),
        .fill_i       (fill_vec),
        .fill_data_i  (mem_rsp_data),
        .rd_tid_i     (rd_tid),
        .tag_o        (buf_tag),
        .valid_o      (buf_valid),
        .epoch_o      (buf_epoch),
        .rd_data_o    (rd_data),
        .rd_tag_o     (rd_tag)
    );

    always_comb begin
        mem_req_valid = issue_any || resend;
        mem_req_addr  = resend ? slot_addr : aligned;
        mem_req_tag   = resend ? slot_tag  : {issue_ep, fetch_tid};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= '0;
        else if (mem_rsp_valid && !(|fill_vec) && drop_q != {CNT_W{1'b1}}) drop_q <= drop_q + 1'b1;
    end

    assign fetch_hit    = |hit_vec;
    assign port_blocked = blocked;
    assign line_valid   = buf_valid;
    assign drop_count   = drop_q;

    // R1
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr & OFF_MASK) == '0);

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!port_blocked && (switched_out || (intr_pending && !fetch_priv))) |-> (!mem_req_valid && !fetch_hit));

    // R2
    hit_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit |-> !mem_req_valid);

    // R8
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rsp_valid |=> $stable(drop_count));

endmodule

// File: tb/line_fetch_req_bench.sv
module line_fetch_req_bench;

    localparam int NUM_THR = 2;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 512;
    localparam int HALF    = 2500;   // picoseconds: 200 MHz clock

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [0:0]        fetch_tid = '0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              fetch_priv = 1'b0;
    logic              intr_pending = 1'b0;
    logic              switched_out = 1'b0;
    logic [1:0]        squash = '0;
    logic [1:0]        stall = '0;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [1:0]        mem_req_tag;
    logic              mem_req_ready = 1'b0;
    logic              mem_retry = 1'b0;
    logic              mem_rsp_valid = 1'b0;
    logic [ADDR_W-1:0] mem_rsp_addr = '0;
    logic [1:0]        mem_rsp_tag = '0;
    logic [DATA_W-1:0] mem_rsp_data = '0;
    logic              fetch_hit;
    logic              port_blocked;
    logic [5:0]        thr_state;
    logic [1:0]        line_valid;
    logic [0:0]        rd_tid = '0;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_tag;
    logic [15:0]       drop_count;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] exp_ep = '0;
    int exp_drop = 0;

    always #HALF clk = ~clk;

    line_fetch_req u_line_fetch_req (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_addr(fetch_addr),
        .fetch_priv(fetch_priv), .intr_pending(intr_pending), .switched_out(switched_out),
        .squash(squash), .stall(stall),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_req_ready(mem_req_ready), .mem_retry(mem_retry),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data),
        .fetch_hit(fetch_hit), .port_blocked(port_blocked), .thr_state(thr_state),
        .line_valid(line_valid), .rd_tid(rd_tid), .rd_data(rd_data), .rd_tag(rd_tag),
        .drop_count(drop_count)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a, input int t);
        return {16{a ^ 32'hA5C3_0000 ^ ADDR_W'(t)}};
    endfunction

    function automatic logic [2:0] st(input int t);
        return thr_state[t*3 +: 3];
    endfunction

    logic              s_v;
    logic [ADDR_W-1:0] s_a;
    logic [1:0]        s_t;
    logic              s_h;

    // Drive a fetch for one cycle; sample combinational outputs mid-cycle.
    task automatic do_fetch(input int t, input logic [ADDR_W-1:0] a, input logic rdy);
        fetch_valid = 1'b1; fetch_tid = 1'(t); fetch_addr = a; mem_req_ready = rdy;
        #1000;
        s_v = mem_req_valid; s_a = mem_req_addr; s_t = mem_req_tag; s_h = fetch_hit;
        @(negedge clk);
        fetch_valid = 1'b0; mem_req_ready = 1'b0;
    endtask

    task automatic do_retry(input logic rdy);
        mem_retry = 1'b1; mem_req_ready = rdy;
        #1000;
        s_v = mem_req_valid; s_a = mem_req_addr; s_t = mem_req_tag;
        @(negedge clk);
        mem_retry = 1'b0; mem_req_ready = 1'b0;
    endtask

    task automatic respond(input int t, input logic ep, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d);
        mem_rsp_valid = 1'b1; mem_rsp_tag = {ep, 1'(t)}; mem_rsp_addr = a; mem_rsp_data = d;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] al;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 state t0", st(0), 0);
        chk("R12 state t1", st(1), 0);
        chk("R12 line_valid", line_valid, 0);
        chk("R12 port_blocked", port_blocked, 0);
        chk("R12 drop_count", drop_count, 0);

        // Address sweep over both threads and many offsets
        for (int t = 0; t < 2; t++) begin
            for (int k = 0; k < 6; k++) begin
                logic [ADDR_W-1:0] a;
                a  = 32'h0001_0000 + ADDR_W'(t) * 32'h0010_0000 + ADDR_W'(k) * 64 + ADDR_W'((k * 23 + 5) % 64);
                al = a & ~32'h3F;
                exp_ep[t] = ~exp_ep[t];
                do_fetch(t, a, 1'b1);
                chk("R1 req valid", s_v, 1);
                chk("R1 req addr aligned", s_a, al);
                chk("R1 req tag", s_t, {exp_ep[t], 1'(t)});
                chk("R2 no hit on miss", s_h, 0);
                rd_tid = 1'(t);
                #1000;
                chk("R4 state wait rsp", st(t), 2);
                chk("R4 line invalid", line_valid[t], 0);
                chk("R4 tag set", rd_tag, al);
                stall[t] = k[0];
                respond(t, exp_ep[t], al, pat(al, t));
                chk("R9 state after fill", st(t), k[0] ? 3'd4 : 3'd3);
                chk("R9 line valid", line_valid[t], 1);
                chk("R9 data stored", rd_data == pat(al, t), 1);
                stall[t] = 1'b0;
                @(negedge clk);
                chk(k[0] ? "R11 blocked to ready" : "R9 done to ready", st(t), 0);
                do_fetch(t, al + ADDR_W'((k * 7 + 3) % 64), 1'b1);
                chk("R2 hit raised", s_h, 1);
                chk("R2 no request on hit", s_v, 0);
            end
        end

        // Gate sweep: switched_out, intr_pending, fetch_priv
        for (int g = 0; g < 8; g++) begin
            logic expect_go;
            logic [ADDR_W-1:0] a;
            a  = 32'h0020_0000 + ADDR_W'(g) * 64 + 4;
            al = a & ~32'h3F;
            expect_go = !g[0] && !(g[1] && !g[2]);
            switched_out = g[0]; intr_pending = g[1]; fetch_priv = g[2];
            do_fetch(0, a, 1'b1);
            switched_out = 1'b0; intr_pending = 1'b0; fetch_priv = 1'b0;
            chk("R3 gate request", s_v, expect_go);
            chk("R3 gate no hit", s_h, 0);
            if (expect_go) begin
                exp_ep[0] = ~exp_ep[0];
                respond(0, exp_ep[0], al, pat(al, 0));
                @(negedge clk);
            end
            chk("R3 state after gate", st(0), 0);
        end

        // Refusal and retry on thread 1
        al = 32'h0030_0040;
        exp_ep[1] = ~exp_ep[1];
        do_fetch(1, 32'h0030_0047, 1'b0);
        chk("R5 refused request shown", s_v, 1);
        chk("R5 state wait retry", st(1), 1);
        chk("R5 port blocked", port_blocked, 1);
        do_fetch(0, 32'h0031_0000, 1'b1);
        chk("R3 blocked port no request", s_v, 0);
        chk("R3 blocked thread0 state", st(0), 0);
        do_retry(1'b0);
        chk("R6 resend valid", s_v, 1);
        chk("R6 resend addr", s_a, al);
        chk("R6 resend tag", s_t, {exp_ep[1], 1'b1});
        chk("R6 refused retry stays blocked", port_blocked, 1);
        chk("R6 refused retry state", st(1), 1);
        do_retry(1'b1);
        chk("R6 accepted resend valid", s_v, 1);
        chk("R6 state wait rsp", st(1), 2);
        chk("R6 unblocked", port_blocked, 0);
        respond(1, exp_ep[1], al, pat(al, 1));
        chk("R9 fill after retry", st(1), 3);
        @(negedge clk);

        // R7 retry with empty slot
        do_retry(1'b1);
        chk("R7 no request", s_v, 0);
        chk("R7 not blocked", port_blocked, 0);

        // R10 squash slot owner
        al = 32'h0040_0080;
        exp_ep[0] = ~exp_ep[0];
        do_fetch(0, 32'h0040_00B0, 1'b0);
        chk("R5 blocked before squash", port_blocked, 1);
        squash[0] = 1'b1;
        @(negedge clk);
        squash[0] = 1'b0;
        chk("R10 squash state", st(0), 0);
        chk("R10 squash unblocks", port_blocked, 0);
        do_retry(1'b1);
        chk("R10 retry after squash no request", s_v, 0);

        // R10 squash outstanding miss
        exp_ep[0] = ~exp_ep[0];
        do_fetch(0, 32'h0040_0081, 1'b1);
        chk("R4 refetch after squash", s_v, 1);
        chk("R10 in wait rsp", st(0), 2);
        squash[0] = 1'b1;
        @(negedge clk);
        squash[0] = 1'b0;
        chk("R10 miss squashed state", st(0), 0);
        respond(0, exp_ep[0], al, pat(al, 0));
        exp_drop++;
        chk("R10 stale response dropped", drop_count, exp_drop);
        chk("R10 line stays invalid", line_valid[0], 0);
        chk("R10 state unchanged", st(0), 0);

        // R8 drop cases
        exp_ep[0] = ~exp_ep[0];
        do_fetch(0, 32'h0040_0090, 1'b1);
        chk("R8 waiting", st(0), 2);
        respond(0, ~exp_ep[0], al, pat(al, 0));
        exp_drop++;
        chk("R8 wrong epoch dropped", drop_count, exp_drop);
        chk("R8 still waiting", st(0), 2);
        respond(0, exp_ep[0], al + 32'h40, pat(al, 0));
        exp_drop++;
        chk("R8 wrong addr dropped", drop_count, exp_drop);
        rd_tid = 1'b1;
        #1000;
        respond(1, exp_ep[1], rd_tag, '0);
        exp_drop++;
        chk("R8 idle thread dropped", drop_count, exp_drop);
        chk("R8 idle thread data kept", rd_data == pat(32'h0030_0040, 1), 1);
        switched_out = 1'b1;
        respond(0, exp_ep[0], al, pat(al, 0));
        switched_out = 1'b0;
        exp_drop++;
        chk("R8 switched out dropped", drop_count, exp_drop);
        chk("R8 still waiting after drops", st(0), 2);
        respond(0, exp_ep[0], al, pat(al, 0));
        chk("R8 correct accepted", st(0), 3);
        chk("R8 no extra drop", drop_count, exp_drop);
        @(negedge clk);

        // R11 stall
        stall[1] = 1'b1;
        @(negedge clk);
        chk("R11 stalled state", st(1), 4);
        do_fetch(1, 32'h0050_0000, 1'b1);
        chk("R11 no request while stalled", s_v, 0);
        chk("R11 no hit while stalled", s_h, 0);
        stall[1] = 1'b0;
        @(negedge clk);
        chk("R11 back to ready", st(1), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule